// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block sits beside an SDRAM controller and watches the stream of decoded commands it issues: row activate, column read, column write, precharge, auto refresh and mode-register load, each tagged with a bank number. It does not issue commands or move data. It keeps per-bank and device-wide elapsed-time counters. A command that arrives before its minimum spacing has passed raises a violation report. Two time-outs are also reported: a row held open beyond its longest allowed time, and a gap between refreshes that is too long.

All limits are given as picosecond parameters together with the clock period in picoseconds. At elaboration each limit becomes a whole number of cycles, rounded up. The command input uses a valid/ready handshake. The monitor never applies back-pressure: `cmd_ready` is always high, so every cycle with `cmd_valid` high is one command. The violation report is a plain one-cycle pulse with a rule code and a bank number. It has no handshake.

Top module: `sdram_cmd_timing_mon`

## Requirements
- R1: Each limit in cycles is the picosecond limit divided by the clock period, rounded up. With the defaults (10 ns clock) the limits are: activate-to-column 2, precharge-to-activate 2, activate-to-precharge minimum 4 and maximum 10000, activate-to-activate on the same bank 6, refresh-to-any-command 7, activate-to-activate on different banks 2, write-to-precharge 2, mode-load-to-activate 2, and refresh window 780. A command whose gap in cycles equals its limit is legal.
- R2: Command codes on `cmd_op` are 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode load, and 7 idle. A rule broken by a command accepted in cycle N shows as `viol_valid` high for exactly cycle N+1, together with its code and the bank of that command. The command still updates every timer as if it had been legal.
- R3: While reset is asserted `viol_valid` stays low and `cmd_ready` stays high. Reset leaves every timer satisfied, so no rule flags the first command after reset.
- R4: A read or write to a bank sooner than the activate-to-column limit after that bank's activate is flagged with code 6. Column commands may follow each other on any cycle.
- R5: An activate sooner than the precharge-to-activate limit after a precharge of the same bank is flagged with code 3.
- R6: A precharge to an open bank sooner than the minimum row-open time after its activate is flagged with code 7.
- R7: A precharge sooner than the write-to-precharge limit after a write to the same bank is flagged with code 8.
- R8: An activate sooner than the same-bank activate-to-activate limit after the previous activate of that bank is flagged with code 4.
- R9: An activate to a bank other than the most recently activated one, sooner than the cross-bank limit after that activate, is flagged with code 5.
- R10: Any command sooner than the refresh recovery limit after a refresh is flagged with code 1.
- R11: An activate sooner than the mode-load limit after a mode load is flagged with code 2.
- R12: When a bank has been open for exactly the maximum row-open time and is not precharged in that cycle, code 9 is reported once for that bank (the lowest such bank if several expire together).
- R13: When the refresh window count is reached since the last refresh (or since reset) and no refresh arrives in that cycle, code 10 with bank 0 is reported once. A refresh that arrives in that very cycle is legal.
- R14: When several rules fire in one cycle, the lowest code wins: 1, 2, 3, 4, 5, 6, 7, 8, 9, 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_ready | output | 1 | Always high; the monitor accepts every command |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_bank | input | BW (2) | Bank addressed by the command |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Rule that was broken (see R4 to R14) |
| viol_bank | output | BW (2) | Bank the violation concerns |

## Verification
Some checks run on every cycle. These cover back-to-back patterns whose outcome follows from the ports alone: an activate then a column command to the same bank, activates to different banks on adjacent cycles, and any command right after a refresh. Other cycle-level checks are that command-caused codes only follow an accepted command, that a refresh time-out never repeats on the next cycle, and that the output is quiet in reset. The exact boundary counts need the bench scenarios: a gap equal to the limit is legal and one cycle shorter is flagged. So do the priority among simultaneous rules, the 10000-cycle row-open time-out, and the 780-cycle refresh window with its just-in-time refresh.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_REF  = 3'd5,
    OP_MRS  = 3'd6,
    OP_IDLE = 3'd7
  } cmd_op_e;

  // lower value = higher priority
  typedef enum logic [3:0] {
    RULE_NONE    = 4'd0,
    RULE_RFC     = 4'd1,
    RULE_MRD     = 4'd2,
    RULE_RP      = 4'd3,
    RULE_RC      = 4'd4,
    RULE_RRD     = 4'd5,
    RULE_RCD     = 4'd6,
    RULE_RAS_MIN = 4'd7,
    RULE_WR      = 4'd8,
    RULE_RAS_MAX = 4'd9,
    RULE_REFI    = 4'd10
  } rule_e;

  // round a picosecond limit up to whole clock cycles
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer
  import sdram_mon_pkg::*;
#(
  parameter int unsigned CW      = 14,
  parameter int unsigned RCD     = 2,
  parameter int unsigned RP      = 2,
  parameter int unsigned RAS_MIN = 4,
  parameter int unsigned RAS_MAX = 10000,
  parameter int unsigned RC      = 6,
  parameter int unsigned WR      = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hit,
  input  cmd_op_e op,
  output logic    rcd_bad,
  output logic    rp_bad,
  output logic    ras_min_bad,
  output logic    rc_bad,
  output logic    wr_bad,
  output logic    ras_expire
);

  localparam logic [CW-1:0] ONE       = CW'(1);
  localparam logic [CW-1:0] RCD_L     = CW'(RCD);
  localparam logic [CW-1:0] RP_L      = CW'(RP);
  localparam logic [CW-1:0] RASMIN_L  = CW'(RAS_MIN);
  localparam logic [CW-1:0] RASMAX_L  = CW'(RAS_MAX);
  localparam logic [CW-1:0] RC_L      = CW'(RC);
  localparam logic [CW-1:0] WR_L      = CW'(WR);
  localparam logic [CW-1:0] ACT_SAT   = CW'(RAS_MAX + 1);

  logic [CW-1:0] since_act, since_pre, since_wr;
  logic          row_open;

  logic is_act, is_pre, is_wr, is_col;
  assign is_act = hit && (op == OP_ACT);
  assign is_pre = hit && (op == OP_PRE);
  assign is_wr  = hit && (op == OP_WR);
  assign is_col = hit && ((op == OP_RD) || (op == OP_WR));

  // counters start saturated: every rule satisfied after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= ACT_SAT;
      since_pre <= RP_L;
      since_wr  <= WR_L;
      row_open  <= 1'b0;
    end else begin
      if (is_act)                    since_act <= ONE;
      else if (since_act < ACT_SAT)  since_act <= since_act + ONE;

      if (is_pre)                    since_pre <= ONE;
      else if (since_pre < RP_L)     since_pre <= since_pre + ONE;

      if (is_wr)                     since_wr <= ONE;
      else if (since_wr < WR_L)      since_wr <= since_wr + ONE;

      if (is_act)      row_open <= 1'b1;
      else if (is_pre) row_open <= 1'b0;
    end
  end

  assign rcd_bad     = is_col && (since_act < RCD_L);
  assign rp_bad      = is_act && (since_pre < RP_L);
  assign rc_bad      = is_act && (since_act < RC_L);
  assign ras_min_bad = is_pre && row_open && (since_act < RASMIN_L);
  assign wr_bad      = is_pre && (since_wr < WR_L);
  assign ras_expire  = row_open && (since_act == RASMAX_L) && !is_pre;

endmodule

// File: rtl/sdram_refresh_wd.sv
module sdram_refresh_wd #(
  parameter int unsigned RFC  = 7,
  parameter int unsigned REFI = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_cmd,
  input  logic ref_cmd,
  output logic rfc_bad,
  output logic refi_expire
);

  localparam int unsigned RW = $clog2(RFC + 1) + 1;
  localparam int unsigned IW = $clog2(REFI + 2);
  localparam logic [RW-1:0] RFC_L   = RW'(RFC);
  localparam logic [IW-1:0] REFI_L  = IW'(REFI);
  localparam logic [IW-1:0] REFI_SAT = IW'(REFI + 1);

  logic [RW-1:0] since_ref;
  logic [IW-1:0] win_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ref <= RFC_L;
      win_cnt   <= '0;
    end else begin
      if (ref_cmd)                 since_ref <= RW'(1);
      else if (since_ref < RFC_L)  since_ref <= since_ref + RW'(1);

      if (ref_cmd)                 win_cnt <= IW'(1);
      else if (win_cnt < REFI_SAT) win_cnt <= win_cnt + IW'(1);
    end
  end

  assign rfc_bad     = any_cmd && (since_ref < RFC_L);
  assign refi_expire = (win_cnt == REFI_L) && !ref_cmd;

endmodule

// File: rtl/sdram_rank_timer.sv
module sdram_rank_timer #(
  parameter int unsigned BW  = 2,
  parameter int unsigned RRD = 2,
  parameter int unsigned MRD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_cmd,
  input  logic          mrs_cmd,
  input  logic [BW-1:0] bank,
  output logic          rrd_bad,
  output logic          mrd_bad
);

  localparam int unsigned MX = (RRD > MRD) ? RRD : MRD;
  localparam int unsigned CW = $clog2(MX + 1) + 1;
  localparam logic [CW-1:0] RRD_L = CW'(RRD);
  localparam logic [CW-1:0] MRD_L = CW'(MRD);

  logic [CW-1:0] since_any_act, since_mrs;
  logic [BW-1:0] last_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_any_act <= RRD_L;
      since_mrs     <= MRD_L;
      last_bank     <= '0;
    end else begin
      if (act_cmd) begin
        since_any_act <= CW'(1);
        last_bank     <= bank;
      end else if (since_any_act < RRD_L) begin
        since_any_act <= since_any_act + CW'(1);
      end
      if (mrs_cmd)                since_mrs <= CW'(1);
      else if (since_mrs < MRD_L) since_mrs <= since_mrs + CW'(1);
    end
  end

  assign rrd_bad = act_cmd && (bank != last_bank) && (since_any_act < RRD_L);
  assign mrd_bad = act_cmd && (since_mrs < MRD_L);

endmodule

// File: rtl/sdram_cmd_timing_mon.sv
module sdram_cmd_timing_mon
  import sdram_mon_pkg::*;
#(
  parameter int unsigned NUM_BANKS    = 4,
  parameter int unsigned CLK_PS       = 10000,
  parameter int unsigned T_RCD_PS     = 15000,
  parameter int unsigned T_RP_PS      = 15000,
  parameter int unsigned T_RAS_MIN_PS = 37000,
  parameter int unsigned T_RAS_MAX_PS = 100000000,
  parameter int unsigned T_RC_PS      = 60000,
  parameter int unsigned T_RFC_PS     = 63000,
  parameter int unsigned T_RRD_PS     = 14000,
  parameter int unsigned T_WR_PS      = 14000,
  parameter int unsigned T_REFI_PS    = 7800000,
  parameter int unsigned MRD_CYC      = 2,
  localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [BW-1:0] cmd_bank,
  output logic          viol_valid,
  output logic [3:0]    viol_code,
  output logic [BW-1:0] viol_bank
);

  localparam int unsigned RCD_CYC     = ps_to_cyc(T_RCD_PS, CLK_PS);
  localparam int unsigned RP_CYC      = ps_to_cyc(T_RP_PS, CLK_PS);
  localparam int unsigned RAS_MIN_CYC = ps_to_cyc(T_RAS_MIN_PS, CLK_PS);
  localparam int unsigned RAS_MAX_CYC = ps_to_cyc(T_RAS_MAX_PS, CLK_PS);
  localparam int unsigned RC_CYC      = ps_to_cyc(T_RC_PS, CLK_PS);
  localparam int unsigned RFC_CYC     = ps_to_cyc(T_RFC_PS, CLK_PS);
  localparam int unsigned RRD_CYC     = ps_to_cyc(T_RRD_PS, CLK_PS);
  localparam int unsigned WR_CYC      = ps_to_cyc(T_WR_PS, CLK_PS);
  localparam int unsigned REFI_CYC    = ps_to_cyc(T_REFI_PS, CLK_PS);
  localparam int unsigned BANK_CW     = $clog2(RAS_MAX_CYC + 2);

  cmd_op_e op;
  logic    fire, real_cmd;

  assign cmd_ready = 1'b1;
  assign op        = cmd_op_e'(cmd_op);
  assign fire      = cmd_valid && cmd_ready;
  assign real_cmd  = fire && (op inside {OP_ACT, OP_RD, OP_WR, OP_PRE, OP_REF, OP_MRS});

  logic [NUM_BANKS-1:0] hit_v, rcd_v, rp_v, ras_min_v, rc_v, wr_v, ras_exp_v;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign hit_v[b] = real_cmd && (cmd_bank == BW'(b));
    sdram_bank_timer #(
      .CW(BANK_CW), .RCD(RCD_CYC), .RP(RP_CYC), .RAS_MIN(RAS_MIN_CYC),
      .RAS_MAX(RAS_MAX_CYC), .RC(RC_CYC), .WR(WR_CYC)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .hit(hit_v[b]), .op(op),
      .rcd_bad(rcd_v[b]), .rp_bad(rp_v[b]), .ras_min_bad(ras_min_v[b]),
      .rc_bad(rc_v[b]), .wr_bad(wr_v[b]), .ras_expire(ras_exp_v[b])
    );
  end

  logic rfc_bad, refi_expire, rrd_bad, mrd_bad;

  sdram_refresh_wd #(.RFC(RFC_CYC), .REFI(REFI_CYC)) u_refresh (
    .clk(clk), .rst_n(rst_n), .any_cmd(real_cmd),
    .ref_cmd(real_cmd && (op == OP_REF)),
    .rfc_bad(rfc_bad), .refi_expire(refi_expire)
  );

  sdram_rank_timer #(.BW(BW), .RRD(RRD_CYC), .MRD(MRD_CYC)) u_rank (
    .clk(clk), .rst_n(rst_n),
    .act_cmd(real_cmd && (op == OP_ACT)),
    .mrs_cmd(real_cmd && (op == OP_MRS)),
    .bank(cmd_bank), .rrd_bad(rrd_bad), .mrd_bad(mrd_bad)
  );

  // lowest bank whose row-open limit expires this cycle
  logic [BW-1:0] exp_bank;
  always_comb begin
    exp_bank = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (ras_exp_v[i]) exp_bank = BW'(i);
    end
  end

  rule_e         nxt_code;
  logic [BW-1:0] nxt_bank;

  always_comb begin
    nxt_code = RULE_NONE;
    nxt_bank = cmd_bank;
    if      (rfc_bad)      nxt_code = RULE_RFC;
    else if (mrd_bad)      nxt_code = RULE_MRD;
    else if (|rp_v)        nxt_code = RULE_RP;
    else if (|rc_v)        nxt_code = RULE_RC;
    else if (rrd_bad)      nxt_code = RULE_RRD;
    else if (|rcd_v)       nxt_code = RULE_RCD;
    else if (|ras_min_v)   nxt_code = RULE_RAS_MIN;
    else if (|wr_v)        nxt_code = RULE_WR;
    else if (|ras_exp_v) begin
      nxt_code = RULE_RAS_MAX;
      nxt_bank = exp_bank;
    end else if (refi_expire) begin
      nxt_code = RULE_REFI;
      nxt_bank = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_valid <= 1'b0;
      viol_code  <= '0;
      viol_bank  <= '0;
    end else begin
      viol_valid <= (nxt_code != RULE_NONE);
      viol_code  <= nxt_code;
      viol_bank  <= (nxt_code != RULE_NONE) ? nxt_bank : '0;
    end
  end

endmodule

// File: rtl/sdram_cmd_timing_chk.sv
module sdram_cmd_timing_chk
  import sdram_mon_pkg::*;
#(
  parameter int unsigned BW      = 2,
  parameter int unsigned RCD_CYC = 2,
  parameter int unsigned RFC_CYC = 7,
  parameter int unsigned RRD_CYC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [2:0]    cmd_op,
  input logic [BW-1:0] cmd_bank,
  input logic          viol_valid,
  input logic [3:0]    viol_code,
  input logic [BW-1:0] viol_bank
);

  logic acc, is_act, is_col, is_ref, is_real;
  assign acc     = rst_n && cmd_valid && cmd_ready;
  assign is_act  = acc && (cmd_op == 3'(OP_ACT));
  assign is_col  = acc && ((cmd_op == 3'(OP_RD)) || (cmd_op == 3'(OP_WR)));
  assign is_ref  = acc && (cmd_op == 3'(OP_REF));
  assign is_real = acc && (cmd_op != 3'(OP_NOP)) && (cmd_op != 3'(OP_IDLE));

  AST_RCD_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((RCD_CYC > 1) && $past(is_act) && is_col && (cmd_bank == $past(cmd_bank))) |=> viol_valid); // R4

  AST_RRD_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((RRD_CYC > 1) && $past(is_act) && is_act && (cmd_bank != $past(cmd_bank))) |=> viol_valid); // R9

  AST_RFC_WINS_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ((RFC_CYC > 1) && $past(is_ref) && is_real) |=> (viol_valid && (viol_code == 4'(RULE_RFC)))); // R10

  AST_CMD_CODE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && (viol_code < 4'(RULE_RAS_MAX))) |-> $past(is_real)); // R2

  AST_REFI_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && (viol_code == 4'(RULE_REFI)) && (viol_bank == '0)) |=> !(viol_valid && (viol_code == 4'(RULE_REFI)))); // R13

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_QUIET_IN_RESET: assert (!viol_valid && cmd_ready); // R3
    end
  end

endmodule

bind sdram_cmd_timing_mon sdram_cmd_timing_chk #(
  .BW(BW), .RCD_CYC(RCD_CYC), .RFC_CYC(RFC_CYC), .RRD_CYC(RRD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_bank(cmd_bank), .viol_valid(viol_valid),
  .viol_code(viol_code), .viol_bank(viol_bank)
);

// File: tb/tb_sdram_cmd_timing_mon.sv
`timescale 1ns/1ps
module tb_sdram_cmd_timing_mon;
  import sdram_mon_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       viol_valid;
  logic [3:0] viol_code;
  logic [1:0] viol_bank;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    logic [3:0] code;
    logic [1:0] bank;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  sdram_cmd_timing_mon dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .viol_valid(viol_valid),
    .viol_code(viol_code), .viol_bank(viol_bank)
  );

  localparam logic [2:0] NOP = 3'(OP_NOP);
  localparam logic [2:0] ACT = 3'(OP_ACT);
  localparam logic [2:0] RD  = 3'(OP_RD);
  localparam logic [2:0] WR  = 3'(OP_WR);
  localparam logic [2:0] PRE = 3'(OP_PRE);
  localparam logic [2:0] REF = 3'(OP_REF);
  localparam logic [2:0] MRS = 3'(OP_MRS);

  // driver: one command per cycle, expectation pushed for the next edge
  task automatic step(input logic [2:0] op, input int bank, input rule_e code,
                      input int ebank, input string req);
    exp_t e;
    @(negedge clk);
    cmd_valid = (op != NOP);
    cmd_op    = op;
    cmd_bank  = 2'(bank);
    e.code = 4'(code);
    e.bank = 2'(ebank);
    e.req  = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(NOP, 0, RULE_NONE, 0, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_op = NOP;
    cmd_bank = 2'd0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      n_checks++;
      if (viol_valid !== 1'b0 || cmd_ready !== 1'b1) begin
        n_fails++;
        $display("FAIL R3 reset: viol_valid=%0b cmd_ready=%0b, expected 0 and 1", viol_valid, cmd_ready);
      end
    end
    rst_n = 1'b1;
  endtask

  // monitor: compare registered output just after each edge
  initial begin
    exp_t e;
    logic ev;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e  = exp_q.pop_front();
        ev = (e.code != 4'd0);
        n_checks++;
        if (viol_valid !== ev || (ev && (viol_code !== e.code || viol_bank !== e.bank))) begin
          n_fails++;
          $display("FAIL %s: got valid=%0b code=%0d bank=%0d, expected valid=%0b code=%0d bank=%0d",
                   e.req, viol_valid, viol_code, viol_bank, ev, e.code, e.bank);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    // reset state and first commands (R3)
    do_reset();
    step(ACT, 1, RULE_NONE, 0, "R3 first act");
    step(PRE, 2, RULE_NONE, 0, "R3 idle bank pre");

    // activate-to-column (R4, R1)
    do_reset();
    step(ACT, 0, RULE_NONE, 0, "R3");
    step(RD,  0, RULE_RCD,  0, "R4 rd gap1");
    step(NOP, 0, RULE_NONE, 0, "R4");
    step(WR,  0, RULE_NONE, 0, "R4 wr gap3");
    step(RD,  0, RULE_NONE, 0, "R4 col each clock");
    step(RD,  0, RULE_NONE, 0, "R4 col each clock");
    step(ACT, 1, RULE_NONE, 0, "R9");
    step(NOP, 0, RULE_NONE, 0, "R1");
    step(RD,  1, RULE_NONE, 0, "R1 rcd gap equals limit");

    // row-open minimum, write recovery, precharge recovery (R6, R7, R5, R14)
    do_reset();
    step(ACT, 0, RULE_NONE,    0, "R3");
    step(NOP, 0, RULE_NONE,    0, "R6");
    step(WR,  0, RULE_NONE,    0, "R4");
    step(PRE, 0, RULE_RAS_MIN, 0, "R6 R14 ras over wr");
    step(ACT, 1, RULE_NONE,    0, "R9");
    idle(3, "R7");
    step(WR,  1, RULE_NONE,    0, "R4");
    step(PRE, 1, RULE_WR,      1, "R7 wr gap1");
    step(ACT, 1, RULE_RP,      1, "R5 rp gap1");

    // same-bank and cross-bank activate spacing (R8, R9)
    do_reset();
    step(ACT, 2, RULE_NONE, 0, "R3");
    step(ACT, 3, RULE_RRD,  3, "R9 gap1");
    step(NOP, 0, RULE_NONE, 0, "R8");
    step(ACT, 2, RULE_RC,   2, "R8 gap3");
    step(ACT, 0, RULE_RRD,  0, "R9 recorded act");
    step(NOP, 0, RULE_NONE, 0, "R9");
    step(ACT, 1, RULE_NONE, 0, "R9 R1 gap equals limit");

    // mode load, refresh recovery and priority (R11, R10, R14)
    do_reset();
    step(MRS, 0, RULE_NONE, 0, "R3");
    step(ACT, 1, RULE_MRD,  1, "R11 gap1");
    step(REF, 0, RULE_NONE, 0, "R10");
    step(RD,  1, RULE_RFC,  1, "R10 rd after ref");
    step(MRS, 0, RULE_RFC,  0, "R10 mrs after ref");
    step(ACT, 3, RULE_RFC,  3, "R14 rfc over mrd");
    idle(3, "R10");
    step(MRS, 0, RULE_NONE, 0, "R10 R1 gap equals limit");
    step(NOP, 0, RULE_NONE, 0, "R11");
    step(ACT, 2, RULE_NONE, 0, "R11 gap equals limit");

    // refresh window (R13)
    do_reset();
    step(REF, 0, RULE_NONE, 0, "R13");
    idle(779, "R13 inside window");
    step(NOP, 0, RULE_REFI, 0, "R13 window reached");
    idle(5, "R13 no repeat");
    step(REF, 0, RULE_NONE, 0, "R13");
    idle(779, "R13 inside window");
    step(REF, 0, RULE_NONE, 0, "R13 just in time");
    idle(3, "R13");

    // row-open maximum (R12)
    do_reset();
    step(ACT, 3, RULE_NONE, 0, "R3");
    for (int i = 1; i < 10000; i++) begin
      if (i % 500 == 0) step(REF, 0, RULE_NONE, 0, "R12 waiting");
      else              step(NOP, 0, RULE_NONE, 0, "R12 waiting");
    end
    step(NOP, 3, RULE_RAS_MAX, 3, "R12 limit reached");
    idle(4, "R12 no repeat");
    step(PRE, 3, RULE_NONE, 0, "R12 late pre");

    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule